// File: doc/BRIEF.md
# Processor Memory Region Decoder

This block sits between the request side of a 32-bit processor and the targets that can answer it: an on-chip instruction memory, an on-chip data memory, a boot ROM, the peripheral IO page and an off-chip bus. For every request it picks at most one target, checks that the access kind (load, store, fetch) and width are allowed there, and flags an access fault when they are not or when the address maps to nothing. It also supplies the processor's reset fetch address.

Which targets exist is set by parameters. An address that misses every implemented on-chip memory is sent to the off-chip bus when that bus is enabled. The boot ROM window and the IO page never go off-chip. Off-chip transactions are tracked one at a time. A transaction that gets no acknowledge and no error within a parameterized number of cycles is closed and reported as a bus fault.

Top module: `mem_region_decoder`

## Requirements
- R1: When the instruction memory is enabled, a request whose offset from the instruction base (default 0x00000000) is below IMEM_BYTES (a power of two) selects `sel_imem` in the same cycle. Loads, stores and fetches are all permitted there.
- R2: When the data memory is enabled, a request whose offset from the data base (default 0x80000000) is below DMEM_BYTES selects `sel_dmem`. If both windows match, the instruction memory wins.
- R3: Addresses from 0xFFFFFE00 upward select `sel_io`. Addresses from 0xFFFF0000 up to 0xFFFF0000+BOOT_BYTES select `sel_boot` when the boot ROM is enabled. Every other address at or above 0xFFFF0000 is unmapped. No address at or above 0xFFFF0000 ever raises `sel_ext`.
- R4: An address that hits neither the boot ROM window, the IO page nor an implemented on-chip memory selects `sel_ext` when the off-chip bus is enabled. When it is disabled, such an address faults.
- R5: With the instruction memory enabled and smaller than the distance to the data base, an address between the end of the instruction memory and the data base faults and is not forwarded, even with the off-chip bus enabled.
- R6: `req_size` encodes 0 = byte, 1 = half-word, 2 = word and 3 = invalid. A half-word needs an even address and a word needs an address that is a multiple of 4. A misaligned access or an invalid size faults.
- R7: `req_kind` encodes 0 = load, 1 = store and 2 = fetch. The following accesses fault: a fetch of any size other than word, a fetch from the data memory or IO page, a store to the boot ROM, and a store narrower than a word to the IO page.
- R8: Whenever a request faults, all selects stay low in that cycle. `acc_fault` is high in the following cycle only, with `acc_fault_kind` holding the faulting `req_kind`; otherwise `acc_fault_kind` reads 0. Both outputs are 0 out of reset.
- R9: `boot_addr` equals 0xFFFF0000 when the boot ROM is enabled and the instruction base otherwise.
- R10: With TIMEOUT > 0, an off-chip request issued in cycle 0 that sees neither `ext_ack` nor `ext_err` in cycles 1 to TIMEOUT is closed at the end of cycle TIMEOUT. `bus_fault` is high for the single cycle after that.
- R11: `ext_err` seen during an open transaction closes it and pulses `bus_fault` in the next cycle. `ext_ack` closes it without a fault, including in cycle TIMEOUT itself. `ext_ack` or `ext_err` with no open transaction has no effect on `bus_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_size | input | 2 | 0 byte, 1 half, 2 word |
| ext_ack | input | 1 | Off-chip transaction acknowledged |
| ext_err | input | 1 | Off-chip transaction ended with error |
| sel_imem | output | 1 | Instruction memory selected |
| sel_dmem | output | 1 | Data memory selected |
| sel_boot | output | 1 | Boot ROM selected |
| sel_io | output | 1 | IO page selected |
| sel_ext | output | 1 | Off-chip bus selected (transaction start) |
| acc_fault | output | 1 | Registered access-fault pulse |
| acc_fault_kind | output | 2 | Kind of the faulting access |
| bus_fault | output | 1 | Registered off-chip error or timeout pulse |
| boot_addr | output | 32 | Reset fetch address |

## Verification
The acknowledge of an off-chip transaction and the expiry of its timeout can fall in the same cycle: the bench raises `ext_ack` exactly in cycle TIMEOUT after the request. The reference model expects the acknowledge to win, which means no `bus_fault` pulse and a closed transaction. A later stray acknowledge is then expected to change nothing. Decode faults and bus faults are compared against the model on every clock, so a timeout pulse that lands next to an unrelated decode fault is judged on both outputs at once.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam logic [31:0] BOOT_BASE = 32'hFFFF_0000;
  localparam logic [31:0] IO_BASE   = 32'hFFFF_FE00;
  localparam int unsigned BOOT_MAX  = 32768;

  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2, ACC_RSVD = 2'd3} acc_kind_e;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} acc_size_e;
  typedef enum logic [2:0] {RG_NONE, RG_IMEM, RG_DMEM, RG_BOOT, RG_IO, RG_EXT} region_e;

  // offset of addr from base lies below span (wraps modulo 2^32)
  function automatic logic in_window(logic [31:0] addr, logic [31:0] base, logic [32:0] span);
    logic [31:0] off;
    off = addr - base;
    return {1'b0, off} < span;
  endfunction

  function automatic logic aligned_ok(logic [1:0] lo, acc_size_e sz);
    case (sz)
      SZ_BYTE: return 1'b1;
      SZ_HALF: return ~lo[0];
      SZ_WORD: return lo == 2'b00;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mrd_region_decode.sv
module mrd_region_decode
  import mrd_pkg::*;
#(
  parameter logic [31:0] IBASE      = 32'h0000_0000,
  parameter logic [31:0] DBASE      = 32'h8000_0000,
  parameter bit          IMEM_EN    = 1'b1,
  parameter bit          DMEM_EN    = 1'b1,
  parameter bit          BOOT_EN    = 1'b1,
  parameter bit          EXT_EN     = 1'b1,
  parameter int unsigned IMEM_BYTES = 16384,
  parameter int unsigned DMEM_BYTES = 8192,
  parameter int unsigned BOOT_BYTES = 4096
) (
  input  logic [31:0] addr,
  output region_e     region,
  output logic        gap_hit
);
  localparam logic [32:0] IMEM_END   = {1'b0, IBASE} + 33'(IMEM_BYTES);
  localparam bit          GAP_EXISTS = IMEM_EN && (IMEM_END < {1'b0, DBASE});

  always_comb begin
    gap_hit = GAP_EXISTS && ({1'b0, addr} >= IMEM_END) && (addr < DBASE);
    region  = RG_NONE;
    if (addr >= IO_BASE) begin
      region = RG_IO;
    end else if (addr >= BOOT_BASE) begin
      if (BOOT_EN && in_window(addr, BOOT_BASE, 33'(BOOT_BYTES))) region = RG_BOOT;
    end else if (IMEM_EN && in_window(addr, IBASE, 33'(IMEM_BYTES))) begin
      region = RG_IMEM;
    end else if (DMEM_EN && in_window(addr, DBASE, 33'(DMEM_BYTES))) begin
      region = RG_DMEM;
    end else if (!gap_hit && EXT_EN) begin
      region = RG_EXT;
    end
  end
endmodule

// File: rtl/mrd_attr_check.sv
module mrd_attr_check
  import mrd_pkg::*;
(
  input  region_e    region,
  input  acc_kind_e  kind,
  input  acc_size_e  size,
  input  logic [1:0] addr_lo,
  output logic       fault
);
  always_comb begin
    fault = 1'b0;
    if (region == RG_NONE)                                  fault = 1'b1;
    if (!aligned_ok(addr_lo, size))                         fault = 1'b1;
    if (kind == ACC_RSVD)                                   fault = 1'b1;
    if (kind == ACC_FETCH && size != SZ_WORD)               fault = 1'b1;
    case (region)
      RG_DMEM: if (kind == ACC_FETCH) fault = 1'b1;
      RG_BOOT: if (kind == ACC_STORE) fault = 1'b1;
      RG_IO:   if (kind == ACC_FETCH || (kind == ACC_STORE && size != SZ_WORD)) fault = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/mrd_ext_timer.sv
module mrd_ext_timer #(
  parameter int unsigned TIMEOUT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  input  logic err,
  output logic pend,
  output logic timeout_evt,
  output logic bus_fault
);
  localparam int CW = (TIMEOUT > 0) ? $clog2(TIMEOUT + 1) : 1;

  logic [CW-1:0] cnt;
  logic          close_evt;

  generate
    if (TIMEOUT > 0) begin : g_tmo
      assign timeout_evt = pend && !ack && !err && (cnt == CW'(TIMEOUT - 1));
      assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (cnt < CW'(TIMEOUT)));
    end else begin : g_no_tmo
      assign timeout_evt = 1'b0;
    end
  endgenerate

  assign close_evt = pend && (ack || err || timeout_evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      cnt       <= '0;
      bus_fault <= 1'b0;
    end else begin
      bus_fault <= pend && (err || timeout_evt);
      if (start) begin
        pend <= 1'b1;
        cnt  <= '0;
      end else if (close_evt) begin
        pend <= 1'b0;
      end else if (pend) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_bus_fault_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault |-> $past(pend));
  assert_single_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !start);
  assert_timeout_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (bus_fault && !pend));
endmodule

// File: rtl/mem_region_decoder.sv
module mem_region_decoder
  import mrd_pkg::*;
#(
  parameter logic [31:0] IBASE      = 32'h0000_0000,
  parameter logic [31:0] DBASE      = 32'h8000_0000,
  parameter bit          IMEM_EN    = 1'b1,
  parameter bit          DMEM_EN    = 1'b1,
  parameter bit          BOOT_EN    = 1'b1,
  parameter bit          EXT_EN     = 1'b1,
  parameter int unsigned IMEM_BYTES = 16384,
  parameter int unsigned DMEM_BYTES = 8192,
  parameter int unsigned BOOT_BYTES = 4096,
  parameter int unsigned TIMEOUT    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_kind,
  input  logic [1:0]  req_size,
  input  logic        ext_ack,
  input  logic        ext_err,
  output logic        sel_imem,
  output logic        sel_dmem,
  output logic        sel_boot,
  output logic        sel_io,
  output logic        sel_ext,
  output logic        acc_fault,
  output logic [1:0]  acc_fault_kind,
  output logic        bus_fault,
  output logic [31:0] boot_addr
);
  region_e region;
  logic    gap_hit;
  logic    decode_fault;
  logic    req_fault;
  logic    pend;
  logic    timeout_evt;

  mrd_region_decode #(
    .IBASE(IBASE), .DBASE(DBASE), .IMEM_EN(IMEM_EN), .DMEM_EN(DMEM_EN),
    .BOOT_EN(BOOT_EN), .EXT_EN(EXT_EN), .IMEM_BYTES(IMEM_BYTES),
    .DMEM_BYTES(DMEM_BYTES), .BOOT_BYTES(BOOT_BYTES)
  ) u_decode (
    .addr(req_addr), .region(region), .gap_hit(gap_hit)
  );

  mrd_attr_check u_attr (
    .region(region), .kind(acc_kind_e'(req_kind)), .size(acc_size_e'(req_size)),
    .addr_lo(req_addr[1:0]), .fault(decode_fault)
  );

  assign req_fault = req_valid && decode_fault;

  always_comb begin
    sel_imem = 1'b0;
    sel_dmem = 1'b0;
    sel_boot = 1'b0;
    sel_io   = 1'b0;
    sel_ext  = 1'b0;
    if (req_valid && !decode_fault) begin
      case (region)
        RG_IMEM: sel_imem = 1'b1;
        RG_DMEM: sel_dmem = 1'b1;
        RG_BOOT: sel_boot = 1'b1;
        RG_IO:   sel_io   = 1'b1;
        RG_EXT:  sel_ext  = 1'b1;
        default: ;
      endcase
    end
  end

  mrd_ext_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(sel_ext), .ack(ext_ack), .err(ext_err),
    .pend(pend), .timeout_evt(timeout_evt), .bus_fault(bus_fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_fault      <= 1'b0;
      acc_fault_kind <= 2'd0;
    end else begin
      acc_fault      <= req_fault;
      acc_fault_kind <= req_fault ? req_kind : 2'd0;
    end
  end

  assign boot_addr = BOOT_EN ? BOOT_BASE : IBASE;

  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_imem, sel_dmem, sel_boot, sel_io, sel_ext}));
  assert_no_high_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ext |-> (req_addr < BOOT_BASE));
  assert_gap_not_forwarded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gap_hit |-> !sel_ext);
  assert_fault_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> $past(req_valid));
  assert_fetch_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_imem || sel_boot || sel_ext) && req_kind == 2'd2) |-> (req_size == 2'd2));
  assert_boot_readonly_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_boot |-> (req_kind != 2'd1));
endmodule

// File: tb/tb_mem_region_decoder.sv
module tb_mem_region_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_size = '0;
  logic        ext_ack = 1'b0;
  logic        ext_err = 1'b0;

  logic s1_i, s1_d, s1_b, s1_io, s1_e, af1, bf1;
  logic s2_i, s2_d, s2_b, s2_io, s2_e, af2, bf2;
  logic [1:0] ak1, ak2;
  logic [31:0] ba1, ba2;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string cur_req = "R8";

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_region_decoder #(.TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_size(req_size), .ext_ack(ext_ack), .ext_err(ext_err),
    .sel_imem(s1_i), .sel_dmem(s1_d), .sel_boot(s1_b), .sel_io(s1_io), .sel_ext(s1_e),
    .acc_fault(af1), .acc_fault_kind(ak1), .bus_fault(bf1), .boot_addr(ba1));

  mem_region_decoder #(.IMEM_EN(1'b0), .BOOT_EN(1'b0), .EXT_EN(1'b0), .TIMEOUT(4)) dut2 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_size(req_size), .ext_ack(ext_ack), .ext_err(ext_err),
    .sel_imem(s2_i), .sel_dmem(s2_d), .sel_boot(s2_b), .sel_io(s2_io), .sel_ext(s2_e),
    .acc_fault(af2), .acc_fault_kind(ak2), .bus_fault(bf2), .boot_addr(ba2));

  // returns {fault, ext, io, boot, dmem, imem}
  function automatic logic [5:0] ref_decode(logic [31:0] addr, logic [1:0] kind, logic [1:0] size,
                                            bit imem_en, bit boot_en, bit ext_en);
    longint a;
    int where; // 0 none 1 imem 2 dmem 3 boot 4 io 5 ext
    bit bad;
    a = longint'({32'b0, addr});
    where = 0;
    if (a >= 64'hFFFF_FE00) where = 4;
    else if (a >= 64'hFFFF_0000) where = (boot_en && a < 64'hFFFF_1000) ? 3 : 0;
    else if (imem_en && a < 64'h4000) where = 1;
    else if (a >= 64'h8000_0000 && a < 64'h8000_2000) where = 2;
    else if (imem_en && a < 64'h8000_0000) where = 0;
    else if (ext_en) where = 5;
    bad = (where == 0) || (size == 2'd3) || (kind == 2'd3);
    if (size == 2'd1 && (a % 2) != 0) bad = 1;
    if (size == 2'd2 && (a % 4) != 0) bad = 1;
    if (kind == 2'd2 && size != 2'd2) bad = 1;
    if (kind == 2'd2 && (where == 2 || where == 4)) bad = 1;
    if (kind == 2'd1 && where == 3) bad = 1;
    if (kind == 2'd1 && where == 4 && size != 2'd2) bad = 1;
    if (bad) return 6'b100000;
    case (where)
      1: return 6'b000001;
      2: return 6'b000010;
      3: return 6'b000100;
      4: return 6'b001000;
      default: return 6'b010000;
    endcase
  endfunction

  // behavioural reference state
  logic exp_af1 = 0, exp_af2 = 0, exp_bf1 = 0, exp_bf2 = 0;
  logic [1:0] exp_ak1 = 0, exp_ak2 = 0;
  bit pend1 = 0;
  int wait1 = 0;

  always @(posedge clk) begin
    logic [5:0] r1, r2;
    r1 = ref_decode(req_addr, req_kind, req_size, 1, 1, 1);
    r2 = ref_decode(req_addr, req_kind, req_size, 0, 0, 0);
    if (!rst_n) begin
      exp_af1 = 0; exp_af2 = 0; exp_bf1 = 0; exp_bf2 = 0;
      exp_ak1 = 0; exp_ak2 = 0; pend1 = 0; wait1 = 0;
    end else begin
      exp_af1 = req_valid && r1[5];
      exp_ak1 = exp_af1 ? req_kind : 2'd0;
      exp_af2 = req_valid && r2[5];
      exp_ak2 = exp_af2 ? req_kind : 2'd0;
      exp_bf2 = 0;
      exp_bf1 = 0;
      if (pend1) begin
        if (ext_ack || ext_err) begin
          pend1 = 0;
          exp_bf1 = ext_err;
        end else begin
          wait1++;
          if (wait1 == TMO) begin
            pend1 = 0;
            exp_bf1 = 1;
          end
        end
      end
      if (req_valid && r1[4]) begin
        pend1 = 1;
        wait1 = 0;
      end
    end
  end

  // per-clock comparison, a quarter period after the falling edge
  always begin
    logic [5:0] r1, r2;
    logic [9:0] act1, exp1, act2, exp2;
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      r1 = ref_decode(req_addr, req_kind, req_size, 1, 1, 1);
      r2 = ref_decode(req_addr, req_kind, req_size, 0, 0, 0);
      if (!req_valid) begin r1[4:0] = '0; r2[4:0] = '0; end
      act1 = {s1_e, s1_io, s1_b, s1_d, s1_i, af1, ak1, bf1, 1'b0};
      exp1 = {r1[4:0], exp_af1, exp_ak1, exp_bf1, 1'b0};
      act2 = {s2_e, s2_io, s2_b, s2_d, s2_i, af2, ak2, bf2, 1'b0};
      exp2 = {r2[4:0], exp_af2, exp_ak2, exp_bf2, 1'b0};
      checks += 2;
      if (act1 !== exp1) begin
        failures++;
        $display("FAIL %s dut addr=%h actual=%b expected=%b", cur_req, req_addr, act1, exp1);
      end
      if (act2 !== exp2) begin
        failures++;
        $display("FAIL %s dut2 addr=%h actual=%b expected=%b", cur_req, req_addr, act2, exp2);
      end
    end
  end

  task automatic access(input logic [31:0] a, input logic [1:0] k, input logic [1:0] s);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_kind = k; req_size = s;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
  endtask

  // ack_at = cycle after the request in which ack/err is raised; 0 = never
  task automatic ext_txn(input logic [31:0] a, input int ack_at, input bit use_err);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_kind = 2'd0; req_size = 2'd2;
    @(negedge clk);
    req_valid = 0;
    if (ack_at > 0) begin
      for (int k = 1; k < ack_at; k++) @(negedge clk);
      if (use_err) ext_err = 1; else ext_ack = 1;
      @(negedge clk);
      ext_ack = 0; ext_err = 0;
    end
    for (int k = 0; k < TMO + 3; k++) @(negedge clk);
  endtask

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    // reset state, R8
    check_val("R8 reset acc_fault", {31'b0, af1}, 32'd0);
    check_val("R8 reset bus_fault", {31'b0, bf1}, 32'd0);
    check_val("R8 reset selects", {27'b0, s1_e, s1_io, s1_b, s1_d, s1_i}, 32'd0);
    // R9 reset address
    check_val("R9 boot_addr with boot ROM", ba1, 32'hFFFF_0000);
    check_val("R9 boot_addr without boot ROM", ba2, 32'h0000_0000);
    @(negedge clk);
    rst_n = 1;

    cur_req = "R1";
    access(32'h0000_0000, 2'd0, 2'd2);
    access(32'h0000_3FFC, 2'd2, 2'd2);
    access(32'h0000_1001, 2'd1, 2'd0);
    cur_req = "R2";
    access(32'h8000_0000, 2'd1, 2'd2);
    access(32'h8000_1FFE, 2'd0, 2'd1);
    cur_req = "R3";
    access(32'hFFFF_0000, 2'd2, 2'd2);
    access(32'hFFFF_0FFC, 2'd0, 2'd2);
    access(32'hFFFF_1000, 2'd0, 2'd2);
    access(32'hFFFF_FDFC, 2'd0, 2'd2);
    access(32'hFFFF_FE00, 2'd1, 2'd2);
    access(32'hFFFF_FFFF, 2'd0, 2'd0);
    cur_req = "R4";
    ext_txn(32'h8000_2000, 2, 0);
    ext_txn(32'hC000_0000, 1, 0);
    access(32'h0000_0100, 2'd0, 2'd2);
    cur_req = "R5";
    access(32'h0000_4000, 2'd0, 2'd2);
    access(32'h7FFF_FFFC, 2'd1, 2'd2);
    cur_req = "R6";
    access(32'h0000_0001, 2'd0, 2'd1);
    access(32'h0000_0002, 2'd0, 2'd2);
    access(32'h0000_0003, 2'd0, 2'd0);
    access(32'h0000_0006, 2'd1, 2'd1);
    access(32'h0000_0004, 2'd0, 2'd3);
    cur_req = "R7";
    access(32'h8000_0010, 2'd2, 2'd2);
    access(32'hFFFF_0010, 2'd1, 2'd2);
    access(32'hFFFF_FE04, 2'd1, 2'd0);
    access(32'hFFFF_FE04, 2'd2, 2'd2);
    access(32'h0000_0010, 2'd2, 2'd1);
    access(32'h0000_0010, 2'd3, 2'd2);
    cur_req = "R10";
    ext_txn(32'h9000_0000, 0, 0);
    cur_req = "R11";
    ext_txn(32'h9000_0004, 3, 1);
    ext_txn(32'h9000_0008, TMO, 0);     // ack in the last window cycle wins
    ext_txn(32'h9000_000C, TMO + 1, 0); // ack after the timeout is stray
    @(negedge clk);
    ext_err = 1; ext_ack = 1;           // stray with nothing open
    @(negedge clk);
    ext_err = 0; ext_ack = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule